// File: doc/BRIEF.md
# Frame-Buffer Memory Arbiter with Pixel Prefetch

This block owns the only port to an external asynchronous SRAM that holds a display frame buffer. A microcontroller reaches that SRAM only through this block. Its chip-select, read and write strobes enter asynchronously and are synchronised into the memory clock, which runs at twice the bus clock. Each strobe assertion then becomes exactly one SRAM read or one SRAM write. While no bus access needs the port, the block fetches consecutive frame-buffer words into an eight-entry pixel queue. A downstream display timing path drains that queue.

A single state machine arbitrates the port. Its states are `ST_IDLE` (decide), `ST_FETCH` (one-cycle prefetch read), `ST_CPU_RD` (one-cycle bus read), and `ST_WR_SETUP`, `ST_WR_PULSE`, `ST_WR_HOLD` (a three-cycle bus write). Its transitions are:
- IDLE→FETCH when the queue is empty, or when no bus request is pending and the queue has room.
- IDLE→CPU_RD or IDLE→WR_SETUP when a bus request is pending and the queue is not empty.
- FETCH→IDLE and CPU_RD→IDLE after one cycle.
- WR_SETUP→WR_PULSE→WR_HOLD→IDLE.

The prefetch address walks the frame window, wraps at its end, and restarts at a frame-start pulse.

Top module: `dmarb_top`

## Requirements
- R1: While reset is held, `sram_oe_n` and `sram_we_n` are 1, `pix_empty` is 1 and `underrun` is 0.
- R2: The pixel queue holds FIFO_DEPTH (default 8) words of DW bits. With no bus traffic and no pops it fills to full and then issues no further reads.
- R3: Prefetch addresses start at FB_BASE and rise by one per fetch. After FB_BASE+FB_WORDS-1 the next fetch address is FB_BASE.
- R4: A one-cycle `frame_start` makes the next prefetch read address FB_BASE and clears `underrun` on the following cycle.
- R5: In ST_IDLE a pending bus request wins over a prefetch. The exception is an empty queue: then one prefetch is issued first.
- R6: The bus strobes pass through a two-stage synchroniser. With the queue full, a read strobe driven before clock edge E1 puts `sram_oe_n` low in the cycle after edge E3 and not earlier.
- R7: A bus read holds `sram_oe_n` low for one cycle at the latched address. The returned word is held on `mcu_rdata` until the next bus read. `mcu_rdata_oe` is 1 exactly while `mcu_cs_n` and `mcu_rd_n` are both 0.
- R8: A bus write drives `sram_wdata_oe` for three cycles and `sram_we_n` low only in the middle one. Address and data are stable across all three. If both strobes are low, the access is a read.
- R9: One strobe assertion yields exactly one SRAM access. Another access needs the strobe released first.
- R10: A pop while `pix_empty` is 1 sets `underrun` and removes nothing.
- R11: `pix_data` shows the oldest queued word. A pop with the queue not empty removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock (twice the bus clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| mcu_cs_n | input | 1 | Bus chip select, active low, asynchronous |
| mcu_rd_n | input | 1 | Bus read strobe, active low, asynchronous |
| mcu_wr_n | input | 1 | Bus write strobe, active low, asynchronous |
| mcu_addr | input | AW | Bus word address |
| mcu_wdata | input | DW | Bus write data |
| mcu_rdata | output | DW | Held read result |
| mcu_rdata_oe | output | 1 | Drive enable for the bus data pins |
| sram_addr | output | AW | SRAM address |
| sram_wdata | output | DW | SRAM write data |
| sram_wdata_oe | output | 1 | Drive enable for the SRAM data pins |
| sram_rdata | input | DW | SRAM read data |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| frame_start | input | 1 | One-cycle frame restart pulse |
| pix_pop | input | 1 | Remove the head pixel word |
| pix_data | output | DW | Head pixel word |
| pix_empty | output | 1 | Pixel queue empty |
| underrun | output | 1 | Pop seen while empty since last frame start |

## Verification
The assertions assume three things about the inputs. The bus holds `mcu_addr` and `mcu_wdata` steady for the whole strobe assertion. The strobe stays low long enough for the access to finish. `frame_start` is a single-cycle pulse. The bench keeps every strobe low for at least eight memory cycles, changes address and data only together with the strobes, and drives all inputs half a period away from the active edge. It pops both faster and slower than the refill rate, so the empty-queue priority, the underrun path and wrap-around all occur.

// File: rtl/dmarb_pkg.sv
`timescale 1ns/1ps
package dmarb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_FETCH    = 3'd1,
        ST_CPU_RD   = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5
    } arb_state_t;
endpackage

// File: rtl/dmarb_sync.sv
`timescale 1ns/1ps
module dmarb_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dmarb_pix_fifo.sv
`timescale 1ns/1ps
module dmarb_pix_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);

    logic [DW-1:0] slots [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          pop_ok;

    assign empty  = (count == '0);
    assign full   = (count == CW'(DEPTH));
    assign pop_ok = pop && !empty;
    assign rdata  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
            if (pop_ok) rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: the arbiter never writes into a full queue
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R2: occupancy never exceeds the depth
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R10: a pop on an empty queue leaves it empty
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/dmarb_fetch_addr.sv
`timescale 1ns/1ps
module dmarb_fetch_addr #(
    parameter int AW       = 18,
    parameter int FB_BASE  = 0,
    parameter int FB_WORDS = 76800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic          advance,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] BASE_A = AW'(FB_BASE);
    localparam logic [AW-1:0] LAST_A = AW'(FB_BASE + FB_WORDS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ptr <= BASE_A;
        else if (reload)  ptr <= BASE_A;
        else if (advance) ptr <= (ptr == LAST_A) ? BASE_A : ptr + 1'b1;
    end

    // R3: the prefetch address stays inside the frame window
    p_ptr_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr >= BASE_A) && (ptr <= LAST_A));
    // R4: a frame-start pulse brings the pointer back to the base
    p_reload_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (ptr == BASE_A));
endmodule

// File: rtl/dmarb_top.sv
`timescale 1ns/1ps
module dmarb_top
    import dmarb_pkg::*;
#(
    parameter int AW          = 18,
    parameter int DW          = 16,
    parameter int FIFO_DEPTH  = 8,
    parameter int FB_BASE     = 0,
    parameter int FB_WORDS    = 76800,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mcu_cs_n,
    input  logic          mcu_rd_n,
    input  logic          mcu_wr_n,
    input  logic [AW-1:0] mcu_addr,
    input  logic [DW-1:0] mcu_wdata,
    output logic [DW-1:0] mcu_rdata,
    output logic          mcu_rdata_oe,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_wdata,
    output logic          sram_wdata_oe,
    input  logic [DW-1:0] sram_rdata,
    output logic          sram_oe_n,
    output logic          sram_we_n,
    input  logic          frame_start,
    input  logic          pix_pop,
    output logic [DW-1:0] pix_data,
    output logic          pix_empty,
    output logic          underrun
);
    localparam int STROBES = 3;

    arb_state_t           state_q, state_d;
    logic [STROBES-1:0]   strobe_raw, strobe_s;
    logic                 rd_req, wr_req, cpu_pending, cpu_grant;
    logic                 cpu_done_q;
    logic [AW-1:0]        cpu_addr_q, fetch_ptr;
    logic [DW-1:0]        cpu_wdata_q, rd_hold_q;
    logic                 fifo_push, fifo_empty, fifo_full;
    logic                 fetch_adv, rd_capture;

    // ---- strobe synchroniser: {cs_n, rd_n, wr_n}
    assign strobe_raw = {mcu_cs_n, mcu_rd_n, mcu_wr_n};

    dmarb_sync #(
        .WIDTH  (STROBES),
        .STAGES (SYNC_STAGES),
        .RST_VAL({STROBES{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (strobe_raw),
        .q    (strobe_s)
    );

    assign rd_req      = !strobe_s[2] && !strobe_s[1];
    assign wr_req      = !strobe_s[2] && !strobe_s[0] && strobe_s[1];
    assign cpu_pending = (rd_req || wr_req) && !cpu_done_q;
    assign cpu_grant   = (state_q == ST_IDLE) && !fifo_empty && cpu_pending;

    // ---- state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---- next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fifo_empty)       state_d = ST_FETCH;
                else if (cpu_pending) state_d = rd_req ? ST_CPU_RD : ST_WR_SETUP;
                else if (!fifo_full)  state_d = ST_FETCH;
                else                  state_d = ST_IDLE;
            end
            ST_FETCH:    state_d = ST_IDLE;
            ST_CPU_RD:   state_d = ST_IDLE;
            ST_WR_SETUP: state_d = ST_WR_PULSE;
            ST_WR_PULSE: state_d = ST_WR_HOLD;
            ST_WR_HOLD:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // ---- outputs decoded from the current state
    always_comb begin
        sram_oe_n     = 1'b1;
        sram_we_n     = 1'b1;
        sram_wdata_oe = 1'b0;
        sram_addr     = cpu_addr_q;
        fetch_adv     = 1'b0;
        fifo_push     = 1'b0;
        rd_capture    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FETCH: begin
                sram_oe_n = 1'b0;
                sram_addr = fetch_ptr;
                fetch_adv = 1'b1;
                fifo_push = 1'b1;
            end
            ST_CPU_RD: begin
                sram_oe_n  = 1'b0;
                rd_capture = 1'b1;
            end
            ST_WR_SETUP: sram_wdata_oe = 1'b1;
            ST_WR_PULSE: begin
                sram_wdata_oe = 1'b1;
                sram_we_n     = 1'b0;
            end
            ST_WR_HOLD:  sram_wdata_oe = 1'b1;
            default: ;
        endcase
    end

    assign sram_wdata   = cpu_wdata_q;
    assign mcu_rdata    = rd_hold_q;
    assign mcu_rdata_oe = !mcu_cs_n && !mcu_rd_n;

    // ---- bus-side datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_addr_q  <= '0;
            cpu_wdata_q <= '0;
            rd_hold_q   <= '0;
            cpu_done_q  <= 1'b0;
        end else begin
            if (cpu_grant) begin
                cpu_addr_q  <= mcu_addr;
                cpu_wdata_q <= mcu_wdata;
            end
            if (rd_capture) rd_hold_q <= sram_rdata;
            if (!(rd_req || wr_req))
                cpu_done_q <= 1'b0;
            else if (state_q == ST_CPU_RD || state_q == ST_WR_HOLD)
                cpu_done_q <= 1'b1;
        end
    end

    // ---- underrun flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      underrun <= 1'b0;
        else if (frame_start)            underrun <= 1'b0;
        else if (pix_pop && fifo_empty)  underrun <= 1'b1;
    end

    dmarb_fetch_addr #(
        .AW      (AW),
        .FB_BASE (FB_BASE),
        .FB_WORDS(FB_WORDS)
    ) u_fetch (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (frame_start),
        .advance(fetch_adv),
        .ptr    (fetch_ptr)
    );

    dmarb_pix_fifo #(
        .DW   (DW),
        .DEPTH(FIFO_DEPTH)
    ) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (fifo_push),
        .wdata(sram_rdata),
        .pop  (pix_pop),
        .rdata(pix_data),
        .empty(fifo_empty),
        .full (fifo_full)
    );

    assign pix_empty = fifo_empty;

    // R8: the write enable is low for a single cycle
    p_we_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> sram_we_n);
    // R8: address and data are already settled when the write enable falls
    p_we_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> ($stable(sram_addr) && $stable(sram_wdata) && sram_wdata_oe));
    // R8: a write and an output enable never overlap
    p_oe_we_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));
    // R4: frame start clears the underrun flag
    p_underrun_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !underrun);
    // R10: a pop on an empty queue raises the underrun flag
    p_underrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_pop && pix_empty && !frame_start) |=> underrun);
    // R5: an empty queue is refilled before any bus access is started
    p_empty_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && pix_empty) |=> (state_q == ST_FETCH));
endmodule

// File: tb/dmarb_top_test.sv
`timescale 1ns/1ps
module dmarb_top_test;
    localparam int    AW       = 12;
    localparam int    DW       = 16;
    localparam int    DEPTH    = 8;
    localparam int    FB_BASE  = 16;
    localparam int    FB_WORDS = 40;
    localparam int    LAST     = FB_BASE + FB_WORDS - 1;
    localparam real   HALF     = 2.5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mcu_cs_n = 1'b1, mcu_rd_n = 1'b1, mcu_wr_n = 1'b1;
    logic [AW-1:0] mcu_addr = '0;
    logic [DW-1:0] mcu_wdata = '0;
    logic [DW-1:0] mcu_rdata;
    logic          mcu_rdata_oe;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_wdata;
    logic          sram_wdata_oe;
    logic [DW-1:0] sram_rdata;
    logic          sram_oe_n, sram_we_n;
    logic          frame_start = 1'b0;
    logic          pix_pop = 1'b0;
    logic [DW-1:0] pix_data;
    logic          pix_empty, underrun;

    always #(HALF) clk = ~clk;

    dmarb_top #(
        .AW(AW), .DW(DW), .FIFO_DEPTH(DEPTH),
        .FB_BASE(FB_BASE), .FB_WORDS(FB_WORDS), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .mcu_cs_n(mcu_cs_n), .mcu_rd_n(mcu_rd_n), .mcu_wr_n(mcu_wr_n),
        .mcu_addr(mcu_addr), .mcu_wdata(mcu_wdata),
        .mcu_rdata(mcu_rdata), .mcu_rdata_oe(mcu_rdata_oe),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .sram_wdata_oe(sram_wdata_oe), .sram_rdata(sram_rdata),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .frame_start(frame_start), .pix_pop(pix_pop),
        .pix_data(pix_data), .pix_empty(pix_empty), .underrun(underrun)
    );

    // ---- SRAM model
    logic [DW-1:0] mem [0:(1<<AW)-1];
    initial for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 7 + 3) ^ 16'h1234;
    assign sram_rdata = mem[sram_addr];
    always @(posedge clk) if (rst_n && !sram_we_n) mem[sram_addr] <= sram_wdata;

    // ---- counters
    int  n_cmp = 0, n_bad = 0;
    bit  run_cmp = 0, finished = 0;
    int  we_lows = 0, rd_slots = 0, last_fetch = -1;
    logic [AW-1:0] rd_watch = '0;
    bit  fetch_watch = 0, fs_watch = 0;

    task automatic cmp(input string tag, input string nm,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    // ---- behavioural reference (state code: 0 idle 1 fetch 2 read 3/4/5 write)
    int            m_st;
    bit            m_done, m_unr;
    logic [AW-1:0] m_caddr;
    logic [DW-1:0] m_cwd, m_hold;
    int            m_ptr;
    logic [DW-1:0] q [$];
    bit s1c, s1r, s1w, s2c, s2r, s2w;

    always @(posedge clk) begin : ref_model
        bit rq, wq, pend, pre_empty, pre_full;
        int nst;
        if (!rst_n) begin
            m_st = 0; m_done = 0; m_unr = 0; m_caddr = '0; m_cwd = '0; m_hold = '0;
            m_ptr = FB_BASE; q.delete();
            s1c = 1; s1r = 1; s1w = 1; s2c = 1; s2r = 1; s2w = 1;
        end else begin
            rq = !s2c && !s2r;
            wq = !s2c && !s2w && s2r;
            pend = (rq || wq) && !m_done;
            pre_empty = (q.size() == 0);
            pre_full  = (q.size() == DEPTH);
            if (m_st == 2) m_hold = mem[m_caddr];
            if (pix_pop && !pre_empty) void'(q.pop_front());
            if (m_st == 1) q.push_back(mem[m_ptr]);
            nst = 0;
            case (m_st)
                0: begin
                    if (pre_empty) nst = 1;
                    else if (pend) begin
                        nst = rq ? 2 : 3;
                        m_caddr = mcu_addr; m_cwd = mcu_wdata;
                    end else if (!pre_full) nst = 1;
                    else nst = 0;
                end
                3: nst = 4;
                4: nst = 5;
                default: nst = 0;
            endcase
            if (frame_start) m_ptr = FB_BASE;
            else if (m_st == 1) m_ptr = (m_ptr == LAST) ? FB_BASE : m_ptr + 1;
            if (!(rq || wq)) m_done = 0;
            else if (m_st == 2 || m_st == 5) m_done = 1;
            if (frame_start) m_unr = 0;
            else if (pix_pop && pre_empty) m_unr = 1;
            s2c = s1c; s2r = s1r; s2w = s1w;
            s1c = mcu_cs_n; s1r = mcu_rd_n; s1w = mcu_wr_n;
            m_st = nst;
        end
    end

    // ---- per-cycle comparison and monitors, away from the active edge
    always @(negedge clk) begin
        if (run_cmp) begin
            logic e_oe_n, e_we_n, e_wdoe, e_rdoe;
            logic [AW-1:0] e_addr;
            e_oe_n = !(m_st == 1 || m_st == 2);
            e_we_n = !(m_st == 4);
            e_wdoe = (m_st >= 3);
            e_addr = (m_st == 1) ? AW'(m_ptr) : m_caddr;
            e_rdoe = !mcu_cs_n && !mcu_rd_n;
            cmp("R5", "sram_oe_n", 32'(sram_oe_n), 32'(e_oe_n));
            cmp("R8", "sram_we_n", 32'(sram_we_n), 32'(e_we_n));
            cmp("R8", "sram_wdata_oe", 32'(sram_wdata_oe), 32'(e_wdoe));
            if (!e_oe_n || !e_we_n) cmp("R3", "sram_addr", 32'(sram_addr), 32'(e_addr));
            if (e_wdoe) cmp("R8", "sram_wdata", 32'(sram_wdata), 32'(m_cwd));
            cmp("R2", "pix_empty", 32'(pix_empty), 32'(q.size() == 0));
            if (q.size() > 0) cmp("R11", "pix_data", 32'(pix_data), 32'(q[0]));
            cmp("R10", "underrun", 32'(underrun), 32'(m_unr));
            cmp("R7", "mcu_rdata_oe", 32'(mcu_rdata_oe), 32'(e_rdoe));
            if (e_rdoe) cmp("R7", "mcu_rdata", 32'(mcu_rdata), 32'(m_hold));
            if (!sram_we_n) we_lows++;
            if (!sram_oe_n && sram_addr == rd_watch && !mcu_rd_n) rd_slots++;
            if (fs_watch && !sram_oe_n) begin
                cmp("R4", "first fetch after frame start", 32'(sram_addr), FB_BASE);
                fs_watch = 0;
            end
            if (fetch_watch && !sram_oe_n) begin
                if (last_fetch == LAST)
                    cmp("R3", "wrap address", 32'(sram_addr), FB_BASE);
                last_fetch = int'(sram_addr);
            end
        end
    end

    task automatic mcu_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int hold);
        @(negedge clk); #1;
        mcu_addr = a; mcu_wdata = d; mcu_cs_n = 0; mcu_wr_n = 0; we_lows = 0;
        repeat (hold) @(negedge clk);
        #1; mcu_cs_n = 1; mcu_wr_n = 1;
        repeat (4) @(negedge clk);
        cmp("R8", "write pulses per access", we_lows, 1);
    endtask

    task automatic mcu_read(input logic [AW-1:0] a, input int hold);
        @(negedge clk); #1;
        mcu_addr = a; mcu_cs_n = 0; mcu_rd_n = 0;
        repeat (hold) @(negedge clk);
        #1; mcu_cs_n = 1; mcu_rd_n = 1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp("R1", "oe_n in reset", 32'(sram_oe_n), 1);
        cmp("R1", "we_n in reset", 32'(sram_we_n), 1);
        cmp("R1", "empty in reset", 32'(pix_empty), 1);
        cmp("R1", "underrun in reset", 32'(underrun), 0);
        #1; rst_n = 1; run_cmp = 1;

        // fill with the bus idle and no pops
        repeat (40) @(negedge clk);
        cmp("R2", "queue full, not empty", 32'(pix_empty), 0);
        cmp("R2", "no read once full", 32'(sram_oe_n), 1);

        // writes, then a timed read of the written word (queue stays full)
        mcu_write(12'd20, 16'hBEEF, 8);
        mcu_write(12'd30, 16'h0F0F, 10);
        @(negedge clk); #1;
        mcu_addr = 12'd20; mcu_cs_n = 0; mcu_rd_n = 0; rd_watch = 12'd20; rd_slots = 0;
        @(negedge clk);
        cmp("R6", "no access after one edge", 32'(sram_oe_n), 1);
        @(negedge clk);
        cmp("R6", "no access after two edges", 32'(sram_oe_n), 1);
        @(negedge clk);
        cmp("R6", "access after three edges", 32'(sram_oe_n), 0);
        cmp("R6", "access address", 32'(sram_addr), 20);
        repeat (15) @(negedge clk);
        cmp("R7", "held read data", 32'(mcu_rdata), 32'h0000BEEF);
        cmp("R7", "read drive enable", 32'(mcu_rdata_oe), 1);
        #1; mcu_cs_n = 1; mcu_rd_n = 1;
        repeat (4) @(negedge clk);
        cmp("R9", "one access per strobe", rd_slots, 1);
        cmp("R7", "drive enable released", 32'(mcu_rdata_oe), 0);
        cmp("R7", "data held after release", 32'(mcu_rdata), 32'h0000BEEF);

        // both strobes low is a read (R8)
        @(negedge clk); #1;
        mcu_addr = 12'd30; mcu_cs_n = 0; mcu_rd_n = 0; mcu_wr_n = 0; we_lows = 0;
        repeat (10) @(negedge clk);
        cmp("R8", "both strobes: no write", we_lows, 0);
        cmp("R8", "both strobes: read data", 32'(mcu_rdata), 32'h00000F0F);
        #1; mcu_cs_n = 1; mcu_rd_n = 1; mcu_wr_n = 1;
        repeat (4) @(negedge clk);

        // drain faster than refill while the bus is busy
        #1; pix_pop = 1;
        mcu_write(12'd25, 16'h1111, 8);
        mcu_read(12'd25, 9);
        repeat (30) @(negedge clk);
        cmp("R10", "underrun after empty pop", 32'(underrun), 1);
        #1; pix_pop = 0;
        @(negedge clk); #1; frame_start = 1; fs_watch = 1;
        @(negedge clk); #1; frame_start = 0;
        cmp("R4", "underrun cleared", 32'(underrun), 0);

        // slow pops with the bus idle: walk across several wraps
        fetch_watch = 1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk); #1; pix_pop = (k % 2 == 0);
        end
        #1; pix_pop = 0; fetch_watch = 0;
        repeat (10) @(negedge clk);

        // mixed traffic with a pop pattern near the refill rate
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); #1; pix_pop = (k % 3 != 0);
            mcu_write(AW'(FB_BASE + 3 * k), DW'(16'hA000 + k), 8 + k);
            mcu_read(AW'(FB_BASE + 3 * k), 8);
        end
        #1; pix_pop = 0;
        repeat (20) @(negedge clk);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(HALF * 2 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule